// File: doc/BRIEF.md
# System Tick Down-Counter

This block is a 24-bit periodic tick source for a processor subsystem. A counter steps down by one on every clock while it is running. Once it has reached zero, the next count loads it again from a programmable reload register. Each step from one to zero is a tick. A tick sets a sticky flag and can raise a one-cycle interrupt pulse. With a reload value of N the block ticks once every N+1 clocks.

Software reaches the block over a small synchronous register bus with three registers: control/status, reload value and current value. Any write to the current-value register forces the counter to zero and drops the flag, whatever the write data. This lets software restart the period cleanly. A read of the control/status register returns the flag and then clears it. The asynchronous active-low reset passes through a two-stage release synchronizer before it reaches the logic.

Top module: `tick_timer`

## Requirements
- R1: After reset, all three registers read as zero and `irq` is low.
- R2: While the run bit (control bit 0) is 1 and the counter is non-zero, the counter drops by one each clock. While the run bit is 0, the counter keeps its value.
- R3: When the counter is zero and the run bit is 1, the next clock loads the reload value. That load is not a tick.
- R4: A write to the current-value register (address 2) sets the counter to 0 and clears the flag, for any write data. This write takes priority over counting in the same cycle.
- R5: With a reload value of 0 and the run bit set, the counter stays at 0, and neither the flag nor `irq` is ever raised.
- R6: The count flag (control bit 16) sets on each one-to-zero step and stays set until cleared. A read of the control register (address 0) returns the flag value before the read, then clears it. A tick in the same cycle as the read leaves the flag set.
- R7: When the interrupt-enable bit (control bit 1) is 1, `irq` is high for exactly one cycle on each tick, in the cycle in which the counter first holds 0. When the interrupt-enable bit is 0, `irq` stays low.
- R8: A read issued in one cycle returns its data on `bus_rdata` in the next cycle. Address 3 reads as zero. Bits 31:24 of the reload and current values read as zero, and control bits other than 0, 1 and 16 read as zero.
- R9: The reload register (address 1) stores write-data bits 23:0 and returns them on read. Control writes update only the run and interrupt-enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index: 0 control, 1 reload, 2 current, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | One-cycle tick interrupt pulse |

## Verification
The bench aims at the cycle where a tick and a bus access meet. If a clear on read were allowed to win over a same-cycle tick, that tick would be lost. If counting were allowed to win over a current-value write, the period restart would be off by one. Reload values of zero and one are driven on purpose. A zero reload that wrongly produced ticks would fire the interrupt every cycle, and a reload of one shows whether wrap and tick timing leave a gap between pulses. The bench also writes all-ones data to the reload and current-value registers. A design that kept the upper bits, or used the data of a current-value write, would return a non-zero readback.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned TK_CNT_W  = 24;
  localparam int unsigned TK_DATA_W = 32;
  localparam int unsigned TK_ADDR_W = 2;

  typedef enum logic [TK_ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_LOAD = 2'd1,
    REG_NOW  = 2'd2,
    REG_RSVD = 2'd3
  } tick_reg_e;

  localparam int unsigned CTRL_RUN_BIT   = 0;
  localparam int unsigned CTRL_IRQEN_BIT = 1;
  localparam int unsigned CTRL_FLAG_BIT  = 16;
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W  = TK_CNT_W,
  parameter int unsigned DATA_W = TK_DATA_W,
  parameter int unsigned ADDR_W = TK_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cur_val,
  input  logic              flag,
  output logic              run,
  output logic              irq_en,
  output logic [CNT_W-1:0]  reload_val,
  output logic              cur_clr,
  output logic              flag_rd_clr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic              rd_en, wr_en;
  tick_reg_e         sel_reg;
  logic              run_q, run_d, ien_q, ien_d, ctrl_we;
  logic [CNT_W-1:0]  load_q, load_d;
  logic              load_we;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rd_en       = bus_sel & ~bus_wr;
    wr_en       = bus_sel & bus_wr;
    sel_reg     = tick_reg_e'(bus_addr);
    ctrl_we     = wr_en & (sel_reg == REG_CTRL);
    load_we     = wr_en & (sel_reg == REG_LOAD);
    cur_clr     = wr_en & (sel_reg == REG_NOW);
    flag_rd_clr = rd_en & (sel_reg == REG_CTRL);
    run_d       = bus_wdata[CTRL_RUN_BIT];
    ien_d       = bus_wdata[CTRL_IRQEN_BIT];
    load_d      = bus_wdata[CNT_W-1:0];
  end

  always_comb begin
    rdata_d = '0;
    unique case (sel_reg)
      REG_CTRL: begin
        rdata_d[CTRL_RUN_BIT]   = run_q;
        rdata_d[CTRL_IRQEN_BIT] = ien_q;
        rdata_d[CTRL_FLAG_BIT]  = flag;
      end
      REG_LOAD: rdata_d = {{PAD_W{1'b0}}, load_q};
      REG_NOW:  rdata_d = {{PAD_W{1'b0}}, cur_val};
      REG_RSVD: rdata_d = '0;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (ctrl_we) begin
      run_q <= run_d;
      ien_q <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= '0;
    else if (load_we) load_q <= load_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign run        = run_q;
  assign irq_en     = ien_q;
  assign reload_val = load_q;
  assign bus_rdata  = rdata_q;
endmodule

// File: rtl/tick_core.sv
module tick_core #(
  parameter int unsigned CNT_W = tick_pkg::TK_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             cur_clr,
  input  logic             flag_rd_clr,
  output logic [CNT_W-1:0] cur_val,
  output logic             flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cur_q, cur_d;
  logic             cur_en;
  logic             flag_q, flag_d;
  logic             irq_q, irq_d;
  logic             tick_hit;

  always_comb begin
    cur_d    = cur_q;
    tick_hit = 1'b0;
    cur_en   = cur_clr | run;
    if (cur_clr) begin
      cur_d = '0;
    end else if (run) begin
      if (cur_q == '0) begin
        cur_d = reload_val;
      end else begin
        cur_d    = cur_q - CNT_ONE;
        tick_hit = (cur_q == CNT_ONE);
      end
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (cur_clr)          flag_d = 1'b0;
    else if (tick_hit)    flag_d = 1'b1;
    else if (flag_rd_clr) flag_d = 1'b0;
    irq_d = tick_hit & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign cur_val = cur_q;
  assign flag    = flag_q;
  assign irq     = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned CNT_W      = TK_CNT_W,
  parameter int unsigned DATA_W     = TK_DATA_W,
  parameter int unsigned ADDR_W     = TK_ADDR_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             rst_sync_n;
  logic             run, irq_en, cur_clr, flag_rd_clr, flag;
  logic [CNT_W-1:0] reload_val, cur_val;

  tick_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .cur_val     (cur_val),
    .flag        (flag),
    .run         (run),
    .irq_en      (irq_en),
    .reload_val  (reload_val),
    .cur_clr     (cur_clr),
    .flag_rd_clr (flag_rd_clr),
    .bus_rdata   (bus_rdata)
  );

  tick_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .run         (run),
    .irq_en      (irq_en),
    .reload_val  (reload_val),
    .cur_clr     (cur_clr),
    .flag_rd_clr (flag_rd_clr),
    .cur_val     (cur_val),
    .flag        (flag),
    .irq         (irq)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W  = tick_pkg::TK_CNT_W,
  parameter int unsigned ADDR_W = tick_pkg::TK_ADDR_W
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              run,
  input logic              irq_en,
  input logic [CNT_W-1:0]  cur_val,
  input logic [CNT_W-1:0]  reload_val,
  input logic              flag,
  input logic              irq
);
  logic now_wr;
  assign now_wr = bus_sel && bus_wr && (bus_addr == 2'd2);

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !now_wr && cur_val != '0) |=> (cur_val == $past(cur_val) - CNT_W'(1)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !now_wr) |=> $stable(cur_val));

  p_wrap_load_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !now_wr && cur_val == '0) |=> (cur_val == $past(reload_val) && !irq));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    now_wr |=> (cur_val == '0 && !flag));

  p_zero_reload_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_val == '0 && reload_val == '0 && !flag) |=> !irq);

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |=> !irq);

  p_irq_state_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (cur_val == '0 && flag));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && !now_wr && cur_val == CNT_W'(1)) |=> flag);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .run        (run),
  .irq_en     (irq_en),
  .cur_val    (cur_val),
  .reload_val (reload_val),
  .flag       (flag),
  .irq        (irq)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int unsigned n_vec, n_bad;
  bit          done;

  // bench model of the register state
  logic [23:0] m_cur, m_load;
  logic        m_run, m_ien, m_flag;
  logic        exp_irq;
  logic [31:0] exp_rdata;
  bit          rd_pending;
  string       rd_tag;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [1:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      2'd0: begin v[0] = m_run; v[1] = m_ien; v[16] = m_flag; end
      2'd1: v = {8'h00, m_load};
      2'd2: v = {8'h00, m_cur};
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string def_tag(input logic [1:0] a);
    case (a)
      2'd0: return "R6";
      2'd1: return "R9";
      2'd2: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic check_outputs();
    n_vec++;
    if (irq !== exp_irq) begin
      n_bad++;
      $display("FAIL R7 irq: actual %0b expected %0b", irq, exp_irq);
    end
    if (rd_pending) begin
      n_vec++;
      if (bus_rdata !== exp_rdata) begin
        n_bad++;
        $display("FAIL %s rdata: actual %08h expected %08h", rd_tag, bus_rdata, exp_rdata);
      end
    end
  endtask

  // one bus cycle: check previous results, drive, update model
  task automatic step(input bit sel, input bit wr, input logic [1:0] a,
                      input logic [31:0] wd, input string tag = "");
    bit tick;
    @(negedge clk);
    check_outputs();
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    tick = 1'b0;
    rd_pending = sel && !wr;
    if (rd_pending) begin
      exp_rdata = model_read(a);
      rd_tag = (tag == "") ? def_tag(a) : tag;
    end
    exp_irq = 1'b0;
    if (sel && wr && a == 2'd2) begin
      m_cur = '0; m_flag = 1'b0;
    end else begin
      if (m_run) begin
        if (m_cur == '0) m_cur = m_load;
        else begin
          m_cur = m_cur - 24'd1;
          tick = (m_cur == '0);
        end
      end
      if (tick) m_flag = 1'b1;
      else if (sel && !wr && a == 2'd0) m_flag = 1'b0;
    end
    exp_irq = tick && m_ien;
    if (sel && wr && a == 2'd0) begin m_run = wd[0]; m_ien = wd[1]; end
    if (sel && wr && a == 2'd1) m_load = wd[23:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 32'h0);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d);
  endtask

  task automatic rd_reg(input logic [1:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'h0, tag);
  endtask

  initial begin
    int wd_cnt;
    wd_cnt = 0;
    while (!done) begin
      @(posedge clk);
      wd_cnt++;
      if (wd_cnt > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", wd_cnt);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    m_cur = '0; m_load = '0; m_run = 1'b0; m_ien = 1'b0; m_flag = 1'b0;
    exp_irq = 1'b0; exp_rdata = '0; rd_pending = 1'b0; rd_tag = "";
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_reg(2'd0, "R1"); rd_reg(2'd1, "R1"); rd_reg(2'd2, "R1"); rd_reg(2'd3, "R1");

    // R9 / R8 reload width and reserved address
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1, "R8");
    rd_reg(2'd3, "R8");
    wr_reg(2'd0, 32'hFFFF_FFFC);
    rd_reg(2'd0, "R8");
    wr_reg(2'd1, 32'h0000_0004);
    rd_reg(2'd1, "R9");

    // R2 / R3 / R7 counting with interrupts
    wr_reg(2'd2, 32'h0);
    wr_reg(2'd0, 32'h3);
    for (int i = 0; i < 12; i++) rd_reg(2'd2, "R3");
    idle(7);
    rd_reg(2'd0, "R6");
    rd_reg(2'd0, "R6");

    // R4 clear during counting with all-ones data
    idle(2);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, "R4");
    rd_reg(2'd0, "R4");

    // R2 hold when stopped
    wr_reg(2'd0, 32'h0);
    idle(5);
    rd_reg(2'd2, "R2");

    // R5 zero reload
    wr_reg(2'd1, 32'h0);
    wr_reg(2'd2, 32'h0);
    wr_reg(2'd0, 32'h3);
    idle(20);
    rd_reg(2'd2, "R5");
    rd_reg(2'd0, "R5");

    // reload of one: tick every other cycle, flag read during ticks
    wr_reg(2'd1, 32'h1);
    for (int i = 0; i < 10; i++) rd_reg(2'd0, "R6");

    // R7 interrupt disabled
    wr_reg(2'd0, 32'h1);
    idle(10);

    // constrained random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [31:0] d;
      r = $urandom % 100;
      d = $urandom;
      if (r < 50)      idle(1);
      else if (r < 75) rd_reg(2'($urandom % 4), "");
      else if (r < 85) wr_reg(2'd1, (r < 80) ? {d[31:24], 21'h0, d[2:0]} : d);
      else if (r < 93) wr_reg(2'd0, d | 32'h1);
      else if (r < 97) wr_reg(2'd2, d);
      else             wr_reg(2'd0, d);
    end
    idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule